// File: doc/BRIEF.md
# Stereo Audio DAC Serializer

This block turns a pair of parallel 16-bit audio samples into the three-wire serial stream an audio DAC expects: a bit clock, a word clock that selects the channel, and one serial data line. All outputs are made in the system clock domain. A rational accumulator decides on which system cycles the bit clock toggles, so a board clock that is not a whole multiple of the bit rate still gives the right average rate. With the default ratio a 101 MHz system clock yields a bit clock near 2.1168 MHz, and 48 bit clocks per stereo frame give 44.1 kHz.

Both samples are captured together once per frame, at the moment the frame begins. A one-cycle latch strobe marks that capture, so the producer of the samples can time its updates to it. Between strobes the sample inputs may change freely without disturbing the frame being sent.

Top module: `dac_serial_tx`

## Requirements
- R1: While reset is held, bclk_o is 1, lrck_o is 1, sdata_o is 0 and latch_o is 0.
- R2: bclk_o toggles on exactly those system cycles where an internal accumulator, which adds RATE_NUM every cycle, reaches RATE_DEN (it then drops by RATE_DEN), and at no other time. RATE_NUM must not exceed RATE_DEN.
- R3: A frame holds 48 bit-clock periods. latch_o pulses high for one system cycle at the start of every frame, so successive pulses lie 96 toggles apart, which is 96*RATE_DEN/RATE_NUM cycles when that ratio is whole.
- R4: Both samples are taken from left_i and right_i on the system edge at which latch_o rises. Values on those inputs at any other time do not affect sdata_o.
- R5: Bit slots are numbered 0 to 47 from the start of the frame. lrck_o is 0 in slots 0 to 23 (left) and 1 in slots 24 to 47 (right).
- R6: In slot 24*h+p (h=0 left, h=1 right), sdata_o carries bit 16-p of that channel's sample for p from 1 to 16, which is MSB first starting one slot after the word-clock edge. It is 0 for p=0 and for p from 17 to 23.
- R7: sdata_o and lrck_o change only on the system edge where bclk_o falls, so they are stable at each rising edge of bclk_o.
- R8: Each rise of latch_o coincides with a fall of lrck_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_i | input | 16 | Left-channel sample, two's complement |
| right_i | input | 16 | Right-channel sample, two's complement |
| bclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Word clock, 0 = left, 1 = right |
| sdata_o | output | 1 | Serial data, updated when bclk_o falls |
| latch_o | output | 1 | One-cycle pulse when both samples are captured |

## Verification
The bench first sends samples whose MSB and LSB differ from their neighbours (0x8001 and 0x7FFE). These expose swapped bit order, off-by-one slot placement and swapped channels. It then sends all-ones against all-zeros, which shows whether the padding slots stay 0 and whether the word clock lines up with the data. Finally the inputs change to new random values every system cycle. This shows whether capture happens only at the frame edge, since a design that reads the inputs later in the frame would send mixed bits. An uneven rate ratio (3/7) spaces the toggles irregularly and so tests the accumulator's pacing and the frame length in cycles.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;

  // Bit of a word sent in position pos of a half frame (pos 0 is the gap
  // after the word-clock edge). Positions past the word width give 0.
  function automatic logic half_slot_bit(input logic [31:0] word,
                                         input int unsigned pos,
                                         input int unsigned width);
    logic [31:0] sh;
    if (pos == 0 || pos > width) return 1'b0;
    sh = word >> (width - pos);
    return sh[0];
  endfunction

  // Width needed to hold the accumulator sum without overflow.
  function automatic int unsigned acc_width(input int unsigned num,
                                            input int unsigned den);
    return $clog2(num + den + 1) + 1;
  endfunction

endpackage

// File: rtl/dac_tick_gen.sv
module dac_tick_gen #(
  parameter int unsigned RATE_NUM = 42336,
  parameter int unsigned RATE_DEN = 1010000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned ACC_W = dac_ser_pkg::acc_width(RATE_NUM, RATE_DEN);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_w;

  assign sum_w  = acc_q + ACC_W'(RATE_NUM);
  assign tick_o = (sum_w >= ACC_W'(RATE_DEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (tick_o) acc_q <= sum_w - ACC_W'(RATE_DEN);
    else             acc_q <= sum_w;
  end
endmodule

// File: rtl/dac_slot_ctr.sv
module dac_slot_ctr #(
  parameter int unsigned FRAME_SLOTS = 48,
  localparam int unsigned SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  output logic              bclk_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] slot_nxt_o,
  output logic              fall_o,
  output logic              wrap_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_SLOTS - 1);

  logic              bclk_q;
  logic [SLOT_W-1:0] slot_q;

  assign fall_o     = tick_i & bclk_q;
  assign wrap_o     = fall_o & (slot_q == LAST);
  assign slot_nxt_o = (slot_q == LAST) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b1;
      slot_q <= LAST;
    end else if (tick_i) begin
      bclk_q <= ~bclk_q;
      if (bclk_q) slot_q <= slot_nxt_o;
    end
  end

  assign bclk_o = bclk_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/dac_word_shift.sv
module dac_word_shift #(
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned HALF_SLOTS = 24,
  localparam int unsigned SLOT_W = $clog2(2 * HALF_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                fall_i,
  input  logic                wrap_i,
  input  logic [SLOT_W-1:0]   slot_nxt_i,
  output logic                lrck_o,
  output logic                sdata_o,
  output logic                latch_o
);
  logic [SAMPLE_W-1:0] word_q [2];
  logic                half_w;
  int unsigned         pos_w;
  logic                bit_w;

  assign half_w = (slot_nxt_i >= SLOT_W'(HALF_SLOTS));
  assign pos_w  = half_w ? int'(slot_nxt_i) - HALF_SLOTS : int'(slot_nxt_i);
  assign bit_w  = dac_ser_pkg::half_slot_bit(32'(word_q[half_w]), pos_w, SAMPLE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q[0] <= '0;
      word_q[1] <= '0;
    end else if (wrap_i) begin
      word_q[0] <= left_i;
      word_q[1] <= right_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_o  <= 1'b1;
      sdata_o <= 1'b0;
      latch_o <= 1'b0;
    end else begin
      latch_o <= wrap_i;
      if (fall_i) begin
        lrck_o  <= half_w;
        sdata_o <= bit_w;
      end
    end
  end
endmodule

// File: rtl/dac_serial_tx.sv
module dac_serial_tx #(
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned HALF_SLOTS = 24,
  parameter int unsigned RATE_NUM   = 42336,
  parameter int unsigned RATE_DEN   = 1010000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                bclk_o,
  output logic                lrck_o,
  output logic                sdata_o,
  output logic                latch_o
);
  localparam int unsigned FRAME_SLOTS = 2 * HALF_SLOTS;
  localparam int unsigned SLOT_W      = $clog2(FRAME_SLOTS);

  logic              tick_w;
  logic              fall_w;
  logic              wrap_w;
  logic [SLOT_W-1:0] slot_w;
  logic [SLOT_W-1:0] slot_nxt_w;

  dac_tick_gen #(.RATE_NUM(RATE_NUM), .RATE_DEN(RATE_DEN)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
  );

  dac_slot_ctr #(.FRAME_SLOTS(FRAME_SLOTS)) u_slot (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .bclk_o(bclk_o),
    .slot_o(slot_w), .slot_nxt_o(slot_nxt_w), .fall_o(fall_w), .wrap_o(wrap_w)
  );

  dac_word_shift #(.SAMPLE_W(SAMPLE_W), .HALF_SLOTS(HALF_SLOTS)) u_shift (
    .clk(clk), .rst_n(rst_n), .left_i(left_i), .right_i(right_i),
    .fall_i(fall_w), .wrap_i(wrap_w), .slot_nxt_i(slot_nxt_w),
    .lrck_o(lrck_o), .sdata_o(sdata_o), .latch_o(latch_o)
  );
endmodule

// File: rtl/dac_serial_tx_chk.sv
module dac_serial_tx_chk #(
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned HALF_SLOTS = 24,
  localparam int unsigned SLOT_W = $clog2(2 * HALF_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_w,
  input logic [SLOT_W-1:0] slot_w,
  input logic              bclk_o,
  input logic              lrck_o,
  input logic              sdata_o,
  input logic              latch_o
);
  // R2: toggles follow the accumulator tick one-to-one
  a_r2_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick_w) |-> (bclk_o != $past(bclk_o)));
  a_r2_no_stray_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_w) |-> $stable(bclk_o));
  // R3: slot index stays inside the frame
  a_r3_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot_w < SLOT_W'(2 * HALF_SLOTS));
  // R5: word clock agrees with the half the slot lies in
  a_r5_lr_half: assert property (@(posedge clk) disable iff (!rst_n)
    lrck_o == (slot_w >= SLOT_W'(HALF_SLOTS)));
  // R6: gap and padding slots send zero
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_w == '0) || (slot_w == SLOT_W'(HALF_SLOTS)) ||
     (slot_w > SLOT_W'(SAMPLE_W) && slot_w < SLOT_W'(HALF_SLOTS)) ||
     (slot_w > SLOT_W'(HALF_SLOTS + SAMPLE_W))) |-> !sdata_o);
  // R7: data and word clock move only with a bit-clock fall
  a_r7_stable_data: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bclk_o) |-> ($stable(sdata_o) && $stable(lrck_o)));
  // R8: capture strobe sits on the left-channel start
  a_r8_latch_lr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_o) |-> $fell(lrck_o));
  // R3: strobe lasts a single cycle
  a_r3_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |=> !latch_o);
endmodule

bind dac_serial_tx dac_serial_tx_chk #(.SAMPLE_W(SAMPLE_W), .HALF_SLOTS(HALF_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_w(tick_w), .slot_w(slot_w),
  .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o), .latch_o(latch_o)
);

// File: tb/sim_dac_serial_tx.sv
`timescale 1ns/1ps
module sim_dac_serial_tx;
  localparam int NUM = 3;
  localparam int DEN = 7;
  localparam int FRAME_CYC = 96 * DEN / NUM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] left_i = '0;
  logic [15:0] right_i = '0;
  logic bclk_o, lrck_o, sdata_o, latch_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_latch = -1;
  int n_frames = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_serial_tx #(.SAMPLE_W(16), .HALF_SLOTS(24), .RATE_NUM(NUM), .RATE_DEN(DEN)) u0 (
    .clk(clk), .rst_n(rst_n), .left_i(left_i), .right_i(right_i),
    .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o), .latch_o(latch_o)
  );

  // Behavioural reference: a queue of {word clock, data} pairs per frame.
  int m_acc = 0;
  bit m_bclk = 1'b1, m_lr = 1'b1, m_sd = 1'b0, m_latch = 1'b0;
  bit [1:0] q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_bclk = 1; m_lr = 1; m_sd = 0; m_latch = 0; q.delete();
    end else begin
      cyc++;
      m_latch = 0;
      m_acc += NUM;
      if (m_acc >= DEN) begin
        m_acc -= DEN;
        if (m_bclk) begin
          m_bclk = 0;
          if (q.size() == 0) begin
            m_latch = 1;
            for (int h = 0; h < 2; h++) begin
              logic [15:0] w;
              w = (h == 0) ? left_i : right_i;
              q.push_back({h[0], 1'b0});
              for (int b = 15; b >= 0; b--) q.push_back({h[0], w[b]});
              for (int k = 0; k < 7; k++) q.push_back({h[0], 1'b0});
            end
          end
          {m_lr, m_sd} = q.pop_front();
        end else begin
          m_bclk = 1;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2", "bclk_o", int'(bclk_o), int'(m_bclk));
      check("R5", "lrck_o", int'(lrck_o), int'(m_lr));
      check("R6 R4", "sdata_o", int'(sdata_o), int'(m_sd));
      check("R3 R8", "latch_o", int'(latch_o), int'(m_latch));
      if (latch_o) begin
        if (last_latch >= 0) check("R3", "frame length", cyc - last_latch, FRAME_CYC);
        last_latch = cyc;
        n_frames++;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "bclk_o reset", int'(bclk_o), 1);
    check("R1", "lrck_o reset", int'(lrck_o), 1);
    check("R1", "sdata_o reset", int'(sdata_o), 0);
    check("R1", "latch_o reset", int'(latch_o), 0);
    left_i = 16'h8001; right_i = 16'h7FFE;
    rst_n = 1'b1;
    // distinct-edge patterns for bit order and channel swap (R6)
    while (n_frames < 3) @(negedge clk);
    left_i = 16'hFFFF; right_i = 16'h0000;
    while (n_frames < 5) @(negedge clk);
    left_i = 16'h0000; right_i = 16'hFFFF;
    while (n_frames < 7) @(negedge clk);
    // R4: inputs change every cycle; only the frame-edge values count
    while (n_frames < 12) begin
      @(negedge clk);
      left_i = 16'($urandom); right_i = 16'($urandom);
    end
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      summary();
    end
  end
endmodule